// File: doc/BRIEF.md
# Step-Down Regulator Sequencing and Protection Supervisor

This block is the digital controller that takes a step-down converter from power-up to regulation and handles its faults. Every input is a flag that analog comparators have already resolved: supply lockout levels for the control and power rails, the enable input, three feedback comparators (above +20 % of reference, below -20 % of reference, and below the low-discharge level), an over-temperature flag, a soft-start-complete flag from the reference ramp, and an overcurrent trip. Its outputs gate the pulse-width modulator, request the soft-start ramp, override the two power switches, switch in the output bleed resistor, and pull the power-good line low.

The two supply flags and the enable input first pass through deglitch filters. Each filter accepts a new level only after the level has held for a set number of clocks, and this applies to both edges. A seven-state machine then follows this flow. IDLE moves to WAIT once everything is ready. WAIT moves to SOFT after a fixed delay. SOFT moves to RUN when the soft-start flag arrives. Each fault has its own reaction:
- Overvoltage goes to OVDIS, a latched hysteretic low-side discharge.
- Undervoltage (checked only in RUN) and overcurrent go to LATCH, a latched soft-off with the bleed path on.
- Over-temperature goes to HOT, which restarts by itself.

OVDIS and LATCH can only be left by dropping enable or the control supply. That returns the machine to IDLE, and the next start runs the full delay and soft-start again. All delays are counts of the system clock.

Top module: `buck_supervisor`

## Requirements
- R1: While reset is asserted, and after it is released with nothing ready, the machine is in IDLE. In IDLE: ss_req=0, pwm_en=0, hs_off=1, ls_on=0, bleed_on=1, pg_low=1.
- R2: A deglitch filter passes a new level of vcc_ok or vin_ok only after that level has held for SUP_DG consecutive clocks. For en_in the hold is EN_DG clocks. Shorter pulses on either edge are ignored.
- R3: Once the filtered vcc_ok, vin_ok and en_in are all high (ready), IDLE moves to WAIT. WAIT holds for WAIT_CYC clocks with hs_off=1 and pwm_en=0, and then moves to SOFT. With all three inputs raised together from IDLE, ss_req rises EN_DG+1+WAIT_CYC clocks later.
- R4: In SOFT, ss_req=1, pwm_en=1 and pg_low=1. The clock edge that samples ss_done=1 moves the machine to RUN, where ss_req=0 and pwm_en=1.
- R5: In WAIT, SOFT, RUN and HOT, fb_over=1 with ready moves the machine to OVDIS on the next clock. On entry to OVDIS: hs_off=1, ls_on=1, pwm_en=0, bleed_on=0.
- R6: In OVDIS, ls_on drops after fb_low=1 is sampled. It rises again after fb_over=1 is sampled. It keeps its value while neither flag is set.
- R7: fb_under has no effect in SOFT. In RUN, fb_under=1 moves the machine to LATCH (soft-off): hs_off=1, bleed_on=1, pwm_en=0, ls_on=0.
- R8: In WAIT, SOFT or RUN, oc_trip=1 moves the machine to LATCH.
- R9: LATCH and OVDIS hold while the filtered en_in and vcc_ok stay high. When either one falls, the machine goes to IDLE. The next start repeats the full WAIT delay and soft-start.
- R10: hot=1 in WAIT, SOFT or RUN moves the machine to HOT: hs_off=1, ls_on=0, bleed_on=0, pwm_en=0. When hot clears, HOT moves straight to SOFT (ss_req=1 on the next clock) with no latch.
- R11: pg_low=0 only in RUN with fb_over=0 and fb_under=0. The feedback terms act combinationally, in the same cycle.
- R12: Loss of ready moves any active state to IDLE first. Among faults sampled in the same cycle, the priority is fb_over, then hot, then oc_trip/fb_under, so overvoltage discharge wins over soft-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Control supply above lockout level (raw) |
| vin_ok | input | 1 | Power supply above lockout level (raw) |
| en_in | input | 1 | Enable request (raw) |
| fb_over | input | 1 | Feedback above +20 % of reference |
| fb_under | input | 1 | Feedback below -20 % of reference |
| fb_low | input | 1 | Feedback below the discharge release level |
| hot | input | 1 | Over-temperature flag (hysteresis in comparator) |
| ss_done | input | 1 | Reference ramp finished |
| oc_trip | input | 1 | Overcurrent protection trip |
| ss_req | output | 1 | Request/run the soft-start ramp |
| pwm_en | output | 1 | Gate for the PWM modulator |
| hs_off | output | 1 | Force high-side switch off |
| ls_on | output | 1 | Force low-side switch on |
| bleed_on | output | 1 | Connect the output bleed resistor |
| pg_low | output | 1 | Pull the open-drain power-good line low |

## Verification
The bench builds the block with SUP_DG=3, EN_DG=5 and WAIT_CYC=8. With these values every deglitch window, the full start-up delay and each latch-clear cycle finish within a few dozen clocks. Directed sequences can therefore count the exact start-up latency after enable and after a supply cycle. A few thousand random cycles can also visit every state and every fault order many times over, each cycle compared with a cycle model written from the requirements. The shortened filters also make it cheap to show that an enable pulse one clock too short never starts the converter.

// File: rtl/bsup_pkg.sv
`timescale 1ns/1ps
package bsup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SOFT,
        ST_RUN,
        ST_LATCH,
        ST_OVDIS,
        ST_HOT
    } bsup_state_e;
endpackage

// File: rtl/bsup_deglitch.sv
`timescale 1ns/1ps
module bsup_deglitch #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (din == dout) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            dout <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bsup_fsm.sv
`timescale 1ns/1ps
module bsup_fsm
    import bsup_pkg::*;
#(
    parameter int WAIT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vcc_q,
    input  logic        vin_q,
    input  logic        en_q,
    input  logic        fb_over,
    input  logic        fb_under,
    input  logic        fb_low,
    input  logic        hot,
    input  logic        ss_done,
    input  logic        oc_trip,
    output bsup_state_e state_o,
    output logic        ss_req,
    output logic        pwm_en,
    output logic        hs_off,
    output logic        ls_on,
    output logic        bleed_on,
    output logic        pg_low
);
    localparam int WCW = $clog2(WAIT_CYC + 1);
    localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYC - 1);

    bsup_state_e    state, nxt;
    logic [WCW-1:0] wcnt;
    logic           dis, dis_nxt;
    logic           ready, hold;

    assign ready   = vcc_q & vin_q & en_q;
    assign hold    = vcc_q & en_q;
    assign state_o = state;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ready) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!ready)              nxt = ST_IDLE;
                else if (fb_over)        nxt = ST_OVDIS;
                else if (hot)            nxt = ST_HOT;
                else if (oc_trip)        nxt = ST_LATCH;
                else if (wcnt == WLAST)  nxt = ST_SOFT;
            end
            ST_SOFT: begin
                if (!ready)              nxt = ST_IDLE;
                else if (fb_over)        nxt = ST_OVDIS;
                else if (hot)            nxt = ST_HOT;
                else if (oc_trip)        nxt = ST_LATCH;
                else if (ss_done)        nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!ready)                   nxt = ST_IDLE;
                else if (fb_over)             nxt = ST_OVDIS;
                else if (hot)                 nxt = ST_HOT;
                else if (oc_trip || fb_under) nxt = ST_LATCH;
            end
            ST_LATCH: if (!hold) nxt = ST_IDLE;
            ST_OVDIS: if (!hold) nxt = ST_IDLE;
            ST_HOT: begin
                if (!ready)              nxt = ST_IDLE;
                else if (fb_over)        nxt = ST_OVDIS;
                else if (!hot)           nxt = ST_SOFT;
            end
            default:                     nxt = ST_IDLE;
        endcase
    end

    // hysteretic discharge control
    always_comb begin
        dis_nxt = 1'b0;
        if (state == ST_OVDIS) begin
            if (fb_low)       dis_nxt = 1'b0;
            else if (fb_over) dis_nxt = 1'b1;
            else              dis_nxt = dis;
        end else if (nxt == ST_OVDIS) begin
            dis_nxt = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            dis   <= 1'b0;
        end else begin
            state <= nxt;
            dis   <= dis_nxt;
            wcnt  <= (state == ST_WAIT && nxt == ST_WAIT) ? wcnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        ss_req   = 1'b0;
        pwm_en   = 1'b0;
        hs_off   = 1'b1;
        ls_on    = 1'b0;
        bleed_on = 1'b0;
        unique case (state)
            ST_IDLE:  bleed_on = 1'b1;
            ST_WAIT:  ;
            ST_SOFT: begin
                ss_req = 1'b1;
                pwm_en = 1'b1;
                hs_off = 1'b0;
            end
            ST_RUN: begin
                pwm_en = 1'b1;
                hs_off = 1'b0;
            end
            ST_LATCH: bleed_on = 1'b1;
            ST_OVDIS: ls_on = dis;
            ST_HOT:   ;
            default:  bleed_on = 1'b1;
        endcase
        pg_low = !(state == ST_RUN && !fb_over && !fb_under);
    end
endmodule

// File: rtl/buck_supervisor.sv
`timescale 1ns/1ps
module buck_supervisor
    import bsup_pkg::*;
#(
    parameter int SUP_DG   = 125,
    parameter int EN_DG    = 375,
    parameter int WAIT_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic vin_ok,
    input  logic en_in,
    input  logic fb_over,
    input  logic fb_under,
    input  logic fb_low,
    input  logic hot,
    input  logic ss_done,
    input  logic oc_trip,
    output logic ss_req,
    output logic pwm_en,
    output logic hs_off,
    output logic ls_on,
    output logic bleed_on,
    output logic pg_low
);
    localparam int NFILT = 3;

    logic [NFILT-1:0] raw_v;
    logic [NFILT-1:0] filt_v;
    logic             vcc_q, vin_q, en_q;
    bsup_state_e      state;

    assign raw_v = {en_in, vin_ok, vcc_ok};
    assign vcc_q = filt_v[0];
    assign vin_q = filt_v[1];
    assign en_q  = filt_v[2];

    for (genvar g = 0; g < NFILT; g++) begin : g_filt
        localparam int LEN = (g == NFILT - 1) ? EN_DG : SUP_DG;
        bsup_deglitch #(.CYCLES(LEN)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_v[g]),
            .dout (filt_v[g])
        );
    end

    bsup_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vcc_q   (vcc_q),
        .vin_q   (vin_q),
        .en_q    (en_q),
        .fb_over (fb_over),
        .fb_under(fb_under),
        .fb_low  (fb_low),
        .hot     (hot),
        .ss_done (ss_done),
        .oc_trip (oc_trip),
        .state_o (state),
        .ss_req  (ss_req),
        .pwm_en  (pwm_en),
        .hs_off  (hs_off),
        .ls_on   (ls_on),
        .bleed_on(bleed_on),
        .pg_low  (pg_low)
    );
endmodule

// File: rtl/bsup_checker.sv
`timescale 1ns/1ps
module bsup_checker
    import bsup_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        en_in,
    input logic        en_q,
    input logic        vcc_q,
    input logic        vin_q,
    input logic        fb_over,
    input logic        fb_under,
    input logic        oc_trip,
    input logic        hot,
    input bsup_state_e state,
    input logic        ss_req,
    input logic        pwm_en,
    input logic        hs_off,
    input logic        ls_on,
    input logic        bleed_on,
    input logic        pg_low
);
    assert_en_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(en_in));

    assert_ss_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |-> (pwm_en && pg_low));

    assert_discharge_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ls_on |-> (hs_off && !pwm_en));

    assert_uv_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFT && fb_under && !fb_over && !hot && !oc_trip
         && en_q && vcc_q && vin_q) |=> (state != ST_LATCH));

    assert_softoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bleed_on |-> (!ls_on && !pwm_en));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && en_q && vcc_q) |=> (state == ST_LATCH));

    assert_hot_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOT) |-> (hs_off && !ls_on && !bleed_on && !pwm_en));

    assert_pg_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_low |-> (pwm_en && !ss_req && !fb_over && !fb_under));

    assert_ov_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && fb_over && en_q && vcc_q && vin_q) |=> (state == ST_OVDIS));
endmodule

bind buck_supervisor bsup_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_in   (en_in),
    .en_q    (en_q),
    .vcc_q   (vcc_q),
    .vin_q   (vin_q),
    .fb_over (fb_over),
    .fb_under(fb_under),
    .oc_trip (oc_trip),
    .hot     (hot),
    .state   (state),
    .ss_req  (ss_req),
    .pwm_en  (pwm_en),
    .hs_off  (hs_off),
    .ls_on   (ls_on),
    .bleed_on(bleed_on),
    .pg_low  (pg_low)
);

// File: tb/sim_buck_supervisor.sv
`timescale 1ns/1ps
module sim_buck_supervisor;
    localparam int SUP = 3;
    localparam int EN  = 5;
    localparam int WT  = 8;

    localparam int M_IDLE = 0, M_WAIT = 1, M_SOFT = 2, M_RUN = 3,
                   M_LAT = 4, M_OVD = 5, M_HOT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 0, vin_ok = 0, en_in = 0, fb_over = 0, fb_under = 0;
    logic fb_low = 0, hot = 0, ss_done = 0, oc_trip = 0;
    logic ss_req, pwm_en, hs_off, ls_on, bleed_on, pg_low;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // cycle model state
    int   m_st = M_IDLE;
    int   m_cnt = 0;
    logic m_dis = 0;
    logic q_vcc = 0, q_vin = 0, q_en = 0;
    int   c_vcc = 0, c_vin = 0, c_en = 0;

    always #4 clk = ~clk;

    buck_supervisor #(.SUP_DG(SUP), .EN_DG(EN), .WAIT_CYC(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vin_ok(vin_ok), .en_in(en_in),
        .fb_over(fb_over), .fb_under(fb_under), .fb_low(fb_low), .hot(hot),
        .ss_done(ss_done), .oc_trip(oc_trip), .ss_req(ss_req), .pwm_en(pwm_en),
        .hs_off(hs_off), .ls_on(ls_on), .bleed_on(bleed_on), .pg_low(pg_low)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic dg(input logic d, input int lim, inout logic q, inout int c);
        if (d == q) c = 0;
        else if (c == lim - 1) begin q = d; c = 0; end
        else c++;
    endtask

    function automatic logic [5:0] model_out();
        logic ss, pw, hs, ls, bl, pg;
        ss = 0; pw = 0; hs = 1; ls = 0; bl = 0;
        case (m_st)
            M_IDLE: bl = 1;
            M_SOFT: begin ss = 1; pw = 1; hs = 0; end
            M_RUN:  begin pw = 1; hs = 0; end
            M_LAT:  bl = 1;
            M_OVD:  ls = m_dis;
            default: ;
        endcase
        pg = !(m_st == M_RUN && !fb_over && !fb_under);
        return {ss, pw, hs, ls, bl, pg};
    endfunction

    task automatic model_step();
        logic rdy, hld, nd;
        int nx;
        rdy = q_vcc & q_vin & q_en;
        hld = q_vcc & q_en;
        nx = m_st;
        case (m_st)
            M_IDLE: if (rdy) nx = M_WAIT;
            M_WAIT: if (!rdy) nx = M_IDLE; else if (fb_over) nx = M_OVD;
                    else if (hot) nx = M_HOT; else if (oc_trip) nx = M_LAT;
                    else if (m_cnt == WT - 1) nx = M_SOFT;
            M_SOFT: if (!rdy) nx = M_IDLE; else if (fb_over) nx = M_OVD;
                    else if (hot) nx = M_HOT; else if (oc_trip) nx = M_LAT;
                    else if (ss_done) nx = M_RUN;
            M_RUN:  if (!rdy) nx = M_IDLE; else if (fb_over) nx = M_OVD;
                    else if (hot) nx = M_HOT; else if (oc_trip || fb_under) nx = M_LAT;
            M_LAT, M_OVD: if (!hld) nx = M_IDLE;
            M_HOT:  if (!rdy) nx = M_IDLE; else if (fb_over) nx = M_OVD;
                    else if (!hot) nx = M_SOFT;
            default: nx = M_IDLE;
        endcase
        if (m_st == M_OVD) nd = fb_low ? 1'b0 : (fb_over ? 1'b1 : m_dis);
        else nd = (nx == M_OVD);
        m_cnt = (m_st == M_WAIT && nx == M_WAIT) ? m_cnt + 1 : 0;
        m_st  = nx;
        m_dis = nd;
        dg(vcc_ok, SUP, q_vcc, c_vcc);
        dg(vin_ok, SUP, q_vin, c_vin);
        dg(en_in,  EN,  q_en,  c_en);
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_dis = 0;
            q_vcc = 0; q_vin = 0; q_en = 0; c_vcc = 0; c_vin = 0; c_en = 0;
        end else begin
            model_step();
        end
        #2;
        chk({cur_tag, " model"}, int'({ss_req, pwm_en, hs_off, ls_on, bleed_on, pg_low}),
            int'(model_out()));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic ticks_to_ss(output int n);
        n = 0;
        do begin tick(); n++; end while (!ss_req && n < 200);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        bit all_bleed;
        void'($urandom(32'd7731));
        #2;
        ticks(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 idle outputs", int'({ss_req, pwm_en, hs_off, ls_on, bleed_on, pg_low}), 'b001011);
        // R2 short enable pulse is ignored
        cur_tag = "R2";
        vcc_ok = 1; vin_ok = 1;
        ticks(5);
        en_in = 1;
        all_bleed = 1;
        for (int i = 0; i < EN - 1; i++) begin tick(); if (!bleed_on) all_bleed = 0; end
        en_in = 0;
        for (int i = 0; i < 14; i++) begin tick(); if (!bleed_on || ss_req) all_bleed = 0; end
        chk("R2 short enable ignored", int'(all_bleed), 1);
        // R3 start-up latency
        cur_tag = "R3";
        en_in = 1;
        ticks_to_ss(n);
        chk("R3 start latency", n, EN + 1 + WT);
        // R4 soft-start, R7 UV masked
        cur_tag = "R4";
        chk("R4 soft-start outputs", int'({ss_req, pwm_en, pg_low}), 'b111);
        fb_under = 1; tick(); fb_under = 0;
        chk("R7 under ignored in soft-start", int'(ss_req), 1);
        ss_done = 1; tick(); ss_done = 0;
        chk("R4 run outputs", int'({ss_req, pwm_en}), 'b01);
        chk("R11 power good released", int'(pg_low), 0);
        // R11 window, R7 UV latch
        cur_tag = "R7";
        fb_under = 1; #1;
        chk("R11 pg low on window exit", int'(pg_low), 1);
        tick(); fb_under = 0;
        chk("R7 under -> soft-off", int'({pwm_en, hs_off, ls_on, bleed_on}), 'b0101);
        ticks(20);
        chk("R9 latch held", int'({ss_req, bleed_on}), 'b01);
        // R9 clear via enable
        cur_tag = "R9";
        en_in = 0; ticks(EN + 1);
        chk("R9 idle after enable low", int'(bleed_on), 1);
        en_in = 1;
        ticks_to_ss(n);
        chk("R9 restart after enable cycle", n, EN + 1 + WT);
        ss_done = 1; tick(); ss_done = 0;
        // R12 priority, R5, R6
        cur_tag = "R12";
        fb_over = 1; oc_trip = 1; tick(); fb_over = 0; oc_trip = 0;
        chk("R12 overvoltage beats overcurrent", int'({pwm_en, hs_off, ls_on, bleed_on}), 'b0110);
        tick();
        chk("R6 discharge holds", int'(ls_on), 1);
        fb_low = 1; tick(); fb_low = 0;
        chk("R6 discharge released", int'(ls_on), 0);
        fb_over = 1; tick(); fb_over = 0;
        chk("R6 discharge reasserted", int'(ls_on), 1);
        ticks(10);
        chk("R9 overvoltage latch held", int'({pwm_en, ls_on, ss_req}), 'b010);
        vcc_ok = 0; ticks(SUP + 1);
        chk("R9 idle after supply drop", int'({ls_on, bleed_on}), 'b01);
        vcc_ok = 1;
        ticks_to_ss(n);
        chk("R9 restart after supply cycle", n, SUP + 1 + WT);
        ss_done = 1; tick(); ss_done = 0;
        // R10 thermal
        cur_tag = "R10";
        hot = 1; tick();
        chk("R10 thermal off", int'({pwm_en, hs_off, ls_on, bleed_on}), 'b0100);
        ticks(5);
        chk("R10 thermal hold", int'(pwm_en), 0);
        hot = 0; tick();
        chk("R10 auto restart", int'(ss_req), 1);
        // R8 overcurrent in soft-start
        cur_tag = "R8";
        oc_trip = 1; tick(); oc_trip = 0;
        chk("R8 overcurrent -> soft-off", int'({pwm_en, bleed_on}), 'b01);
        en_in = 0; ticks(EN + 2); en_in = 1;
        // random phase
        cur_tag = "R12 random";
        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            r = $urandom;
            if (r % 257 == 0) en_in = ~en_in;
            if (r % 911 == 3) vcc_ok = ~vcc_ok;
            if (r % 1031 == 5) vin_ok = ~vin_ok;
            if (r % 409 == 7) hot = ~hot;
            r = $urandom;
            fb_over  = (r % 120 == 0);
            fb_low   = (r % 3 == 0);
            fb_under = ((r >> 8) % 160 == 0);
            oc_trip  = ((r >> 8) % 500 == 1);
            ss_done  = ((r >> 16) % 15 == 0);
            if (!en_in && ((r >> 20) % 60 == 0)) en_in = 1;
            if (!vcc_ok && ((r >> 20) % 40 == 1)) vcc_ok = 1;
            if (!vin_ok && ((r >> 20) % 40 == 2)) vin_ok = 1;
            if (hot && ((r >> 24) % 30 == 0)) hot = 0;
            tick();
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule